// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block steps through a ring of transmit descriptors kept in a small register-based descriptor store. Each descriptor is 64 bits wide. The bits are laid out as follows: bits [63:32] hold the buffer pointer, bits [31:16] hold the byte length, and bits [15:0] hold the status flags. The status flags are READY at bit 0, WRAP at bit 1, LAST (end of frame) at bit 2 and CRC (append a frame check sequence) at bit 3. Software fills descriptors through a write port and reads them back through a read port. To arm a frame, software sets READY together with LAST and CRC, and then pulses a kick input to set the engine's active bit.

While it is active, the engine examines the descriptor at its current index. A ready descriptor is handed to the frame output as a pointer, a length and the CRC and LAST flags, using a valid/ready handshake. The engine then waits for a transmit-done pulse from the framing logic. After that it writes the descriptor's status back with READY cleared and moves the index forward. When the engine meets a descriptor that is not ready, it clears the active bit and keeps the index on that descriptor.

A graceful-stop request lets the frame in flight finish and then parks the engine, which signals this with a one-cycle completion pulse. Dropping the controller enable abandons all work and returns the index to the ring base.

Top module: `tbd_ring_engine`

## Requirements
- R1: After reset, `active`, `frm_valid` and `stop_done` are low and every descriptor in the store reads as zero.
- R2: A `kick` pulse while `ctl_enable` is high sets `active` on the next clock. A `kick` while `ctl_enable` is low has no effect.
- R3: While active and not stopping, the engine takes the descriptor at its index if READY (bit 0) is set. It presents that descriptor's pointer and length, CRC (bit 3) as `frm_crc` and LAST (bit 2) as `frm_last` with `frm_valid`. Ready descriptors are sent one frame per descriptor, in index order.
- R4: After a `tx_done` pulse, the engine writes the descriptor back with READY cleared. The WRAP, LAST and CRC flags, the length and the pointer are left unchanged.
- R5: After a descriptor whose WRAP bit (bit 1) is set, the index returns to `ring_base`. Without WRAP, the index goes to the next entry, and from the last entry of the store it goes to entry 0.
- R6: A descriptor found with READY clear makes `active` fall, and the index stays on that descriptor. The index moves only after a writeback, so a later kick resumes at that descriptor.
- R7: `active` falls only after the last frame's writeback. Once `active` is low, every descriptor that was sent reads back with READY clear.
- R8: A one-entry ring (a single descriptor with both WRAP and READY set) is sent exactly once per arming.
- R9: While `stop_req` is high, the frame in flight completes and is written back, and no new descriptor is taken. On entering the stopped state, `stop_done` pulses high for exactly one cycle. `active` keeps its value, and dropping `stop_req` resumes processing.
- R10: With `ctl_enable` low, `active` and `frm_valid` are low one clock later and any frame in flight is abandoned without writeback. The index is loaded from `ring_base`.
- R11: While `frm_valid` is high and `frm_ready` is low, `frm_valid`, `frm_ptr` and `frm_len` hold steady.
- R12: A software write stores the whole 64-bit descriptor at `sw_addr` on the next clock. `sw_rdata` shows the descriptor at `sw_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enable; low resets index to ring base and clears active |
| ring_base | input | IDXW | Index of the first descriptor of the ring |
| kick | input | 1 | Pulse that sets the active bit |
| stop_req | input | 1 | Graceful-stop request level |
| active | output | 1 | Descriptor processing active bit |
| stop_done | output | 1 | One-cycle graceful-stop-complete event |
| sw_we | input | 1 | Software descriptor write strobe |
| sw_addr | input | IDXW | Software descriptor index |
| sw_wdata | input | 64 | Descriptor to write |
| sw_rdata | output | 64 | Descriptor at sw_addr |
| frm_valid | output | 1 | Frame request valid |
| frm_ready | input | 1 | Frame request accepted |
| frm_ptr | output | 32 | Buffer pointer of the frame |
| frm_len | output | 16 | Byte length of the frame |
| frm_crc | output | 1 | Append CRC for this frame |
| frm_last | output | 1 | Buffer ends the frame |
| tx_done | input | 1 | Pulse: framing logic has finished the accepted frame |

## Verification
The embedded assertions check several properties on every cycle:
- a writeback leaves READY clear in the addressed entry, and a software write lands whole;
- the index stays put unless a writeback advances it;
- the frame request is stable under back-pressure;
- `stop_done` is a single-cycle pulse, and no request follows a stop seen in idle;
- `active` falls only from the idle decision point;
- disable clears `active` and `frm_valid`.

Some behaviours can only be shown by the bench's scenarios:
- that ring order and wrap targets match what was armed, for every ring base and length;
- that a one-entry ring sends once;
- that an abandoned frame is resent from the ring base;
- that stopping and resuming lose or repeat no descriptor.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int PTR_W  = 32;
  localparam int LEN_W  = 16;
  localparam int FLG_W  = 16;
  localparam int DESC_W = PTR_W + LEN_W + FLG_W;

  // status flag positions, decoded by software and by the engine
  localparam int F_READY = 0;
  localparam int F_WRAP  = 1;
  localparam int F_LAST  = 2;
  localparam int F_CRC   = 3;

  typedef struct packed {
    logic [PTR_W-1:0] ptr;
    logic [LEN_W-1:0] len;
    logic [FLG_W-1:0] flg;
  } tbd_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd1,
    ST_WAIT = 3'd2,
    ST_WB   = 3'd3,
    ST_HALT = 3'd4
  } tbd_state_e;
endpackage

// File: rtl/tbd_store.sv
module tbd_store
  import tbd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  logic [IDXW-1:0] sw_addr,
  input  tbd_desc_t       sw_wdata,
  output tbd_desc_t       sw_rdata,
  input  logic            eng_we,
  input  logic [IDXW-1:0] eng_addr,
  input  logic [FLG_W-1:0] eng_flg,
  output tbd_desc_t       eng_rdata
);
  tbd_desc_t        ent_rd [DEPTH];
  logic [DEPTH-1:0] rdy_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [IDXW-1:0] GI = IDXW'(g);
    tbd_desc_t e_q;
    tbd_desc_t e_d;
    logic      e_en;

    // software rewrite of an entry wins over the status writeback
    always_comb begin
      e_d  = e_q;
      e_en = 1'b0;
      if (sw_we && (sw_addr == GI)) begin
        e_d  = sw_wdata;
        e_en = 1'b1;
      end else if (eng_we && (eng_addr == GI)) begin
        e_d.flg = eng_flg;
        e_en    = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_q <= '0;
      end else if (e_en) begin
        e_q <= e_d;
      end
    end

    assign ent_rd[g]  = e_q;
    assign rdy_vec[g] = e_q.flg[F_READY];
  end

  assign sw_rdata  = ent_rd[sw_addr];
  assign eng_rdata = ent_rd[eng_addr];

  AST_WB_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && !(sw_we && (sw_addr == eng_addr))) |=> !rdy_vec[$past(eng_addr)])
    else $error("writeback left READY set"); // R4

  AST_SW_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (ent_rd[$past(sw_addr)] == $past(sw_wdata)))
    else $error("software write lost"); // R12
endmodule

// File: rtl/tbd_index.sv
module tbd_index #(
  parameter int DEPTH = 8,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [IDXW-1:0] base,
  input  logic            advance,
  input  logic            wrap,
  output logic [IDXW-1:0] idx
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DEPTH - 1);

  logic [IDXW-1:0] idx_q;
  logic [IDXW-1:0] idx_d;
  logic            idx_en;

  always_comb begin
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (!enable) begin
      idx_d  = base;
      idx_en = 1'b1;
    end else if (advance) begin
      idx_en = 1'b1;
      if (wrap) begin
        idx_d = base;
      end else if (idx_q == LAST_IDX) begin
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$past(advance)) |-> $stable(idx))
    else $error("index moved without writeback"); // R6
endmodule

// File: rtl/tbd_seq.sv
module tbd_seq
  import tbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_enable,
  input  logic             kick,
  input  logic             stop_req,
  input  tbd_desc_t        cur_desc,
  input  logic             frm_ready,
  input  logic             tx_done,
  output logic             active,
  output logic             stop_done,
  output logic             frm_valid,
  output logic [PTR_W-1:0] frm_ptr,
  output logic [LEN_W-1:0] frm_len,
  output logic             frm_crc,
  output logic             frm_last,
  output logic             wb_we,
  output logic [FLG_W-1:0] wb_flg,
  output logic             adv,
  output logic             adv_wrap
);
  tbd_state_e st_q, st_d;
  logic       act_q, act_d;
  logic       done_q, done_d;
  logic       ld_en;
  tbd_desc_t  hold_q;

  always_comb begin
    st_d   = st_q;
    act_d  = act_q;
    done_d = 1'b0;
    ld_en  = 1'b0;
    wb_we  = 1'b0;
    adv    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (stop_req) begin
          st_d   = ST_HALT;
          done_d = 1'b1;
        end else if (act_q) begin
          if (cur_desc.flg[F_READY]) begin
            ld_en = 1'b1;
            st_d  = ST_SEND;
          end else begin
            act_d = 1'b0;
          end
        end
      end
      ST_SEND: if (frm_ready) st_d = ST_WAIT;
      ST_WAIT: if (tx_done) st_d = ST_WB;
      ST_WB: begin
        wb_we = 1'b1;
        adv   = 1'b1;
        st_d  = ST_IDLE;
      end
      ST_HALT: if (!stop_req) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (kick) act_d = 1'b1;
    if (!ctl_enable) begin
      st_d   = ST_IDLE;
      act_d  = 1'b0;
      done_d = 1'b0;
      ld_en  = 1'b0;
      wb_we  = 1'b0;
      adv    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (ld_en) begin
      hold_q <= cur_desc;
    end
  end

  always_comb begin
    wb_flg          = hold_q.flg;
    wb_flg[F_READY] = 1'b0;
  end

  assign adv_wrap  = hold_q.flg[F_WRAP];
  assign active    = act_q;
  assign stop_done = done_q;
  assign frm_valid = (st_q == ST_SEND);
  assign frm_ptr   = hold_q.ptr;
  assign frm_len   = hold_q.len;
  assign frm_crc   = hold_q.flg[F_CRC];
  assign frm_last  = hold_q.flg[F_LAST];

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready && ctl_enable) |=> (frm_valid && $stable(frm_ptr) && $stable(frm_len)))
    else $error("frame request changed under back-pressure"); // R11

  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !stop_done)
    else $error("stop event longer than one cycle"); // R9

  AST_STOP_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && ctl_enable && (st_q == ST_IDLE)) |=> !frm_valid)
    else $error("descriptor taken during stop"); // R9

  AST_ACT_FALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active) && $past(ctl_enable)) |-> ($past(st_q) == ST_IDLE))
    else $error("active fell before writeback"); // R7

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> (!active && !frm_valid))
    else $error("disable did not clear engine"); // R10
endmodule

// File: rtl/tbd_ring_engine.sv
module tbd_ring_engine
  import tbd_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic [IDXW-1:0]   ring_base,
  input  logic              kick,
  input  logic              stop_req,
  output logic              active,
  output logic              stop_done,
  input  logic              sw_we,
  input  logic [IDXW-1:0]   sw_addr,
  input  logic [DESC_W-1:0] sw_wdata,
  output logic [DESC_W-1:0] sw_rdata,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [PTR_W-1:0]  frm_ptr,
  output logic [LEN_W-1:0]  frm_len,
  output logic              frm_crc,
  output logic              frm_last,
  input  logic              tx_done
);
  tbd_desc_t        sw_wd_s;
  tbd_desc_t        sw_rd_s;
  tbd_desc_t        cur_desc;
  logic [IDXW-1:0]  cur_idx;
  logic             wb_we;
  logic [FLG_W-1:0] wb_flg;
  logic             adv;
  logic             adv_wrap;

  assign sw_wd_s  = tbd_desc_t'(sw_wdata);
  assign sw_rdata = sw_rd_s;

  tbd_store #(.DEPTH(DEPTH), .IDXW(IDXW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (sw_we),
    .sw_addr   (sw_addr),
    .sw_wdata  (sw_wd_s),
    .sw_rdata  (sw_rd_s),
    .eng_we    (wb_we),
    .eng_addr  (cur_idx),
    .eng_flg   (wb_flg),
    .eng_rdata (cur_desc)
  );

  tbd_index #(.DEPTH(DEPTH), .IDXW(IDXW)) u_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (ctl_enable),
    .base    (ring_base),
    .advance (adv),
    .wrap    (adv_wrap),
    .idx     (cur_idx)
  );

  tbd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_enable (ctl_enable),
    .kick       (kick),
    .stop_req   (stop_req),
    .cur_desc   (cur_desc),
    .frm_ready  (frm_ready),
    .tx_done    (tx_done),
    .active     (active),
    .stop_done  (stop_done),
    .frm_valid  (frm_valid),
    .frm_ptr    (frm_ptr),
    .frm_len    (frm_len),
    .frm_crc    (frm_crc),
    .frm_last   (frm_last),
    .wb_we      (wb_we),
    .wb_flg     (wb_flg),
    .adv        (adv),
    .adv_wrap   (adv_wrap)
  );
endmodule

// File: tb/sim_tbd_ring_engine.sv
`timescale 1ns/1ps
module sim_tbd_ring_engine;
  localparam int DEPTH = 8;
  localparam int IW    = 3;
  localparam int MAXF  = 1024;

  logic          clk = 1'b0;
  logic          rst_n, ctl_enable, kick, stop_req, sw_we;
  logic [IW-1:0] ring_base, sw_addr;
  logic [63:0]   sw_wdata, sw_rdata;
  logic          frm_valid, frm_ready, frm_crc, frm_last, tx_done;
  logic [31:0]   frm_ptr;
  logic [15:0]   frm_len;
  logic          active, stop_done;

  int checks = 0;
  int errors = 0;
  int got_n = 0;
  int stop_cnt = 0;
  int cyc = 0;
  logic [31:0] got_ptr [MAXF];
  logic [15:0] got_len [MAXF];
  logic [1:0]  got_fl  [MAXF];

  always #2 clk = ~clk;

  tbd_ring_engine #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ring_base(ring_base),
    .kick(kick), .stop_req(stop_req), .active(active), .stop_done(stop_done),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_ptr(frm_ptr), .frm_len(frm_len),
    .frm_crc(frm_crc), .frm_last(frm_last), .tx_done(tx_done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] p, input logic [15:0] l,
                                     input logic rdy, input logic wr, input logic lst, input logic crc);
    return {p, l, 12'h000, crc, lst, wr, rdy};
  endfunction

  function automatic logic [31:0] eptr(input int b, input int n, input int k);
    return {8'hA5, 8'(b), 8'(n), 8'(k)};
  endfunction

  function automatic logic [15:0] elen(input int b, input int n, input int k);
    return 16'(40 + 5 * k + 3 * b + n);
  endfunction

  // frame sink: periodic back-pressure, done pulse three cycles after acceptance
  initial begin
    int pend;
    logic held;
    logic [31:0] hptr;
    pend = 0;
    held = 1'b0;
    hptr = '0;
    frm_ready = 1'b0;
    tx_done = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (held) chk("R11 hold", {frm_valid, frm_ptr}, {1'b1, hptr});
      held = 1'b0;
      tx_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) tx_done = 1'b1;
      end
      frm_ready = (cyc % 3) != 0;
      if (frm_valid && frm_ready) begin
        got_ptr[got_n] = frm_ptr;
        got_len[got_n] = frm_len;
        got_fl[got_n]  = {frm_crc, frm_last};
        got_n++;
        pend = 3;
      end else if (frm_valid && rst_n && ctl_enable) begin
        held = 1'b1;
        hptr = frm_ptr;
      end
      if (stop_done) stop_cnt++;
    end
  end

  task automatic wr_desc(input int idx, input logic [63:0] d);
    @(negedge clk);
    sw_we = 1'b1;
    sw_addr = IW'(idx);
    sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic peek(input int idx, output logic [63:0] d);
    @(negedge clk);
    sw_addr = IW'(idx);
    #1;
    d = sw_rdata;
  endtask

  task automatic do_kick();
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic set_base(input int b);
    @(negedge clk);
    ctl_enable = 1'b0;
    ring_base = IW'(b);
    @(negedge clk);
    ctl_enable = 1'b1;
  endtask

  task automatic wait_quiet();
    int lim;
    lim = 0;
    while ((active || frm_valid) && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
    chk("R7 engine went idle", 64'(lim < 3000), 64'd1);
  endtask

  task automatic wait_frames(input int target);
    int lim;
    lim = 0;
    while (got_n < target && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    int start;
    int sc0;
    rst_n = 1'b0; ctl_enable = 1'b0; kick = 1'b0; stop_req = 1'b0;
    sw_we = 1'b0; sw_addr = '0; sw_wdata = '0; ring_base = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {61'd0, active, frm_valid, stop_done}, 64'd0);
    rst_n = 1'b1;
    peek(5, rd);
    chk("R1 store cleared", rd, 64'd0);

    // R2: kick ignored while disabled; R12 write/readback
    wr_desc(0, mk(32'hC0DE0000, 16'd64, 1'b1, 1'b1, 1'b1, 1'b1));
    peek(0, rd);
    chk("R12 readback", rd, mk(32'hC0DE0000, 16'd64, 1'b1, 1'b1, 1'b1, 1'b1));
    start = got_n;
    do_kick();
    repeat (4) @(negedge clk);
    chk("R2 kick while disabled", {63'd0, active}, 64'd0);
    chk("R2 no frame while disabled", 64'(got_n - start), 64'd0);
    set_base(0);
    do_kick();
    chk("R2 kick sets active", {63'd0, active}, 64'd1);
    wait_quiet();
    chk("R3 one frame", 64'(got_n - start), 64'd1);
    chk("R3 pointer", 64'(got_ptr[start]), 64'h0C0DE0000);

    // sweep every ring base and length; last entry carries WRAP
    for (int b = 0; b < DEPTH; b++) begin
      for (int n = 1; n <= DEPTH - b; n++) begin
        set_base(b);
        for (int k = 0; k < n; k++)
          wr_desc(b + k, mk(eptr(b, n, k), elen(b, n, k), 1'b1, k == n - 1, k % 2 == 0, (b + k) % 2 == 1));
        start = got_n;
        do_kick();
        wait_quiet();
        if (n == 1) chk("R8 single-entry sent once", 64'(got_n - start), 64'd1);
        else        chk("R3 frame count", 64'(got_n - start), 64'(n));
        for (int k = 0; k < n; k++) begin
          chk("R3 order pointer", 64'(got_ptr[start + k]), 64'(eptr(b, n, k)));
          chk("R3 length", 64'(got_len[start + k]), 64'(elen(b, n, k)));
          chk("R3 crc/last", 64'(got_fl[start + k]), {62'd0, 1'((b + k) % 2 == 1), 1'(k % 2 == 0)});
          peek(b + k, rd);
          chk("R7 ready clear after active low", 64'(rd[0]), 64'd0);
          chk("R4 rest of descriptor kept", rd,
              mk(eptr(b, n, k), elen(b, n, k), 1'b0, k == n - 1, k % 2 == 0, (b + k) % 2 == 1));
        end
        // after WRAP the index is back at the base
        wr_desc(b, mk(32'hBA5E0000 + 32'(b), 16'd9, 1'b1, n == 1, 1'b1, 1'b0));
        start = got_n;
        do_kick();
        wait_quiet();
        chk("R5 wrap returns to base", 64'(got_n - start), 64'd1);
        chk("R5 base pointer", 64'(got_ptr[start]), 64'(32'hBA5E0000 + 32'(b)));
      end
    end

    // R5 end-of-store rollover without WRAP, then R6 resume
    set_base(DEPTH - 2);
    wr_desc(DEPTH - 2, mk(32'h11110006, 16'd20, 1'b1, 1'b0, 1'b1, 1'b1));
    wr_desc(DEPTH - 1, mk(32'h11110007, 16'd21, 1'b1, 1'b0, 1'b1, 1'b1));
    wr_desc(0,         mk(32'h11110000, 16'd22, 1'b1, 1'b0, 1'b1, 1'b1));
    wr_desc(1,         mk(32'h11110001, 16'd23, 1'b0, 1'b0, 1'b1, 1'b1));
    start = got_n;
    do_kick();
    wait_quiet();
    chk("R5 rollover count", 64'(got_n - start), 64'd3);
    chk("R5 rollover to entry 0", 64'(got_ptr[start + 2]), 64'h11110000);
    chk("R6 active fell at not-ready", {63'd0, active}, 64'd0);
    wr_desc(1, mk(32'h11110001, 16'd23, 1'b1, 1'b0, 1'b1, 1'b1));
    start = got_n;
    do_kick();
    wait_quiet();
    chk("R6 resumed at held index", 64'(got_ptr[start]), 64'h11110001);

    // R9 graceful stop
    set_base(0);
    wr_desc(2, mk(32'h0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr_desc(0, mk(32'h22220000, 16'd30, 1'b1, 1'b0, 1'b1, 1'b1));
    wr_desc(1, mk(32'h22220001, 16'd31, 1'b1, 1'b0, 1'b1, 1'b1));
    start = got_n;
    sc0 = stop_cnt;
    do_kick();
    wait_frames(start + 1);
    stop_req = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 only current frame", 64'(got_n - start), 64'd1);
    chk("R9 one stop event", 64'(stop_cnt - sc0), 64'd1);
    chk("R9 active kept", {63'd0, active}, 64'd1);
    peek(0, rd);
    chk("R9 current frame written back", 64'(rd[0]), 64'd0);
    stop_req = 1'b0;
    wait_quiet();
    chk("R9 resumed frame", 64'(got_ptr[start + 1]), 64'h22220001);

    // R10 disable mid-frame
    set_base(0);
    wr_desc(0, mk(32'h33330000, 16'd40, 1'b1, 1'b0, 1'b1, 1'b1));
    wr_desc(1, mk(32'h33330001, 16'd41, 1'b1, 1'b0, 1'b1, 1'b1));
    wr_desc(2, mk(32'h33330002, 16'd42, 1'b1, 1'b1, 1'b1, 1'b1));
    start = got_n;
    do_kick();
    wait_frames(start + 2);
    ctl_enable = 1'b0;
    @(negedge clk);
    chk("R10 cleared", {62'd0, active, frm_valid}, 64'd0);
    repeat (10) @(negedge clk);
    peek(1, rd);
    chk("R10 abandoned frame not written back", 64'(rd[0]), 64'd1);
    wr_desc(0, mk(32'h33339999, 16'd43, 1'b1, 1'b0, 1'b1, 1'b1));
    ring_base = '0;
    @(negedge clk);
    ctl_enable = 1'b1;
    start = got_n;
    do_kick();
    wait_quiet();
    chk("R10 restart count", 64'(got_n - start), 64'd3);
    chk("R10 restart from base", 64'(got_ptr[start]), 64'h33339999);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule